// File: doc/BRIEF.md
# Three-Requester Video Memory Arbiter

This block lets three requesters share one single-port synchronous RAM, one access per clock cycle. The processor port has absolute precedence: any cycle in which it asserts its chip enable, it owns the memory. The drawing-engine port and the display-refresh port take turns on the cycles the processor leaves free. A one-bit turn pointer decides which of the two goes first when both are waiting.

Each request carries an address, a 16-bit write word, an active-low write enable and an active-low chip enable. The memory side uses the same signals. The refresh port can only read, so when it is granted the arbiter drives a zero write word and keeps the write enable inactive. The RAM returns read data one cycle after the access. The arbiter records which port owned the previous cycle and steers the returned word to that port only. The drawing engine and the refresh unit are told in the grant cycle that their data will be valid next cycle. The processor needs no such flag because its latency is always one cycle.

Top module: `vram_arbiter3`

## Requirements
- R1: When `cpu_ce_n` is low, the memory bus carries the processor's address, write word and write enable with `mem_ce_n` low, and neither `eng_ack_nxt` nor `rfr_ack_nxt` is set.
- R2: When the processor is idle and exactly one lower-priority port requests, that port drives the memory bus and its ack flag is high in the same cycle.
- R3: When the processor is idle and both lower-priority ports request, the engine is served first after reset. After that, the port that did not take the last lower-priority grant is served.
- R4: The turn pointer changes only on a lower-priority grant. A lower-priority request blocked by the processor gets no flag and is served in the first cycle the processor is idle.
- R5: During a refresh grant, `mem_we_n` is high and `mem_wdata` is zero.
- R6: With no chip enable low, `mem_ce_n` and `mem_we_n` are high and both ack flags are low.
- R7: The word on `mem_rdata` in the cycle after a read grant appears on the read-data output of the port granted in that earlier cycle. The read-data outputs of the other ports are zero.
- R8: The processor receives its read data exactly one cycle after it requests, with no flag.
- R9: While reset is held low, `mem_ce_n` is high, both flags are low, and all read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_we_n | input | 1 | Processor write enable, active low |
| cpu_ce_n | input | 1 | Processor chip enable, active low |
| cpu_rdata | output | DATA_W | Processor read data |
| eng_addr | input | ADDR_W | Drawing-engine address |
| eng_wdata | input | DATA_W | Drawing-engine write word |
| eng_we_n | input | 1 | Drawing-engine write enable, active low |
| eng_ce_n | input | 1 | Drawing-engine chip enable, active low |
| eng_rdata | output | DATA_W | Drawing-engine read data |
| eng_ack_nxt | output | 1 | Engine access taken, data valid next cycle |
| rfr_addr | input | ADDR_W | Refresh read address |
| rfr_ce_n | input | 1 | Refresh chip enable, active low |
| rfr_rdata | output | DATA_W | Refresh read data |
| rfr_ack_nxt | output | 1 | Refresh access taken, data valid next cycle |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write word |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_rdata | input | DATA_W | RAM read word |

## Verification
The assertions check on every cycle that the processor pre-empts the other two ports, that the flags are mutually exclusive, that an idle cycle leaves the RAM deselected, that refresh never writes, and that a granted port sees the RAM word one cycle later. Alternation under sustained contention is also checked cycle by cycle, through a one-step property on back-to-back grants. Only the bench scenarios show the full picture. They hold a blocked request across several processor cycles, check that the pointer stays put while the processor holds the memory, and run long random mixes against a memory model with real stored contents. Those scenarios show that the value each port receives is the word actually stored at its address.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_ENG  = 2'd2,
    OWN_RFR  = 2'd3
  } owner_e;
endpackage

// File: rtl/vram_arb_pick.sv
module vram_arb_pick
  import vram_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cpu_req,
  input  logic   eng_req,
  input  logic   rfr_req,
  output owner_e pick
);
  logic eng_first_q, eng_first_d;
  logic turn_en;

  always_comb begin
    if (cpu_req)                  pick = OWN_CPU;
    else if (eng_req && rfr_req)  pick = eng_first_q ? OWN_ENG : OWN_RFR;
    else if (eng_req)             pick = OWN_ENG;
    else if (rfr_req)             pick = OWN_RFR;
    else                          pick = OWN_NONE;
  end

  always_comb begin
    turn_en     = (pick == OWN_ENG) || (pick == OWN_RFR);
    eng_first_d = (pick == OWN_RFR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eng_first_q <= 1'b1;
    else if (turn_en) eng_first_q <= eng_first_d;
  end
endmodule

// File: rtl/vram_arb_mux.sv
module vram_arb_mux
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  owner_e              pick,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_we_n,
  input  logic [ADDR_W-1:0]   eng_addr,
  input  logic [DATA_W-1:0]   eng_wdata,
  input  logic                eng_we_n,
  input  logic [ADDR_W-1:0]   rfr_addr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we_n,
  output logic                mem_ce_n
);
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we_n  = 1'b1;
    mem_ce_n  = 1'b1;
    unique case (pick)
      OWN_CPU: begin
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        mem_we_n  = cpu_we_n;
        mem_ce_n  = 1'b0;
      end
      OWN_ENG: begin
        mem_addr  = eng_addr;
        mem_wdata = eng_wdata;
        mem_we_n  = eng_we_n;
        mem_ce_n  = 1'b0;
      end
      OWN_RFR: begin
        mem_addr  = rfr_addr;
        mem_ce_n  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vram_arb_steer.sv
module vram_arb_steer
  import vram_arb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  owner_e            pick,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] eng_rdata,
  output logic [DATA_W-1:0] rfr_rdata
);
  owner_e last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= OWN_NONE;
    else        last_q <= pick;
  end

  always_comb begin
    cpu_rdata = (last_q == OWN_CPU) ? mem_rdata : '0;
    eng_rdata = (last_q == OWN_ENG) ? mem_rdata : '0;
    rfr_rdata = (last_q == OWN_RFR) ? mem_rdata : '0;
  end
endmodule

// File: rtl/vram_arbiter3.sv
module vram_arbiter3
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we_n,
  input  logic              cpu_ce_n,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_we_n,
  input  logic              eng_ce_n,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              eng_ack_nxt,
  input  logic [ADDR_W-1:0] rfr_addr,
  input  logic              rfr_ce_n,
  output logic [DATA_W-1:0] rfr_rdata,
  output logic              rfr_ack_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we_n,
  output logic              mem_ce_n,
  input  logic [DATA_W-1:0] mem_rdata
);
  owner_e pick;

  vram_arb_pick u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (!cpu_ce_n),
    .eng_req (!eng_ce_n),
    .rfr_req (!rfr_ce_n),
    .pick    (pick)
  );

  vram_arb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .pick      (pick),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we_n  (cpu_we_n),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_we_n  (eng_we_n),
    .rfr_addr  (rfr_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we_n  (mem_we_n),
    .mem_ce_n  (mem_ce_n)
  );

  vram_arb_steer #(.DATA_W(DATA_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .mem_rdata (mem_rdata),
    .cpu_rdata (cpu_rdata),
    .eng_rdata (eng_rdata),
    .rfr_rdata (rfr_rdata)
  );

  assign eng_ack_nxt = (pick == OWN_ENG);
  assign rfr_ack_nxt = (pick == OWN_RFR);
endmodule

// File: rtl/vram_arbiter3_chk.sv
module vram_arbiter3_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ce_n,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              eng_ce_n,
  input logic [DATA_W-1:0] eng_rdata,
  input logic              eng_ack_nxt,
  input logic              rfr_ce_n,
  input logic              rfr_ack_nxt,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we_n,
  input logic              mem_ce_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata
);
  AST_CPU_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce_n |-> (!eng_ack_nxt && !rfr_ack_nxt && !mem_ce_n && mem_addr == cpu_addr)); // R1
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_ack_nxt, rfr_ack_nxt})); // R2
  AST_FLAG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack_nxt |-> !eng_ce_n) and (rfr_ack_nxt |-> !rfr_ce_n)); // R2
  AST_ENG_THEN_RFR: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack_nxt && !rfr_ce_n) |=> (!cpu_ce_n || rfr_ce_n || rfr_ack_nxt)); // R3
  AST_RFR_THEN_ENG: assert property (@(posedge clk) disable iff (!rst_n)
    (rfr_ack_nxt && !eng_ce_n) |=> (!cpu_ce_n || eng_ce_n || eng_ack_nxt)); // R3
  AST_RFR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rfr_ack_nxt |-> (mem_we_n && mem_wdata == '0)); // R5
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce_n && eng_ce_n && rfr_ce_n) |-> (mem_ce_n && mem_we_n && !eng_ack_nxt && !rfr_ack_nxt)); // R6
  AST_ENG_DATA_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack_nxt |=> (eng_rdata == mem_rdata)); // R7
  AST_CPU_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce_n |=> (cpu_rdata == mem_rdata && eng_rdata == '0)); // R8
endmodule

bind vram_arbiter3 vram_arbiter3_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_vram_arbiter3.sv
`timescale 1ns/1ps
module test_vram_arbiter3;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int G_NONE = 0, G_CPU = 1, G_ENG = 2, G_RFR = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] cpu_addr, eng_addr, rfr_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, eng_wdata, mem_wdata, mem_rdata;
  logic [DW-1:0] cpu_rdata, eng_rdata, rfr_rdata;
  logic cpu_we_n, cpu_ce_n, eng_we_n, eng_ce_n, rfr_ce_n;
  logic eng_ack_nxt, rfr_ack_nxt, mem_we_n, mem_ce_n;
  logic [DW-1:0] ram [0:15];

  int n_cmp = 0, n_bad = 0;
  int eng_first = 1;
  int prev_g = G_NONE;
  logic prev_rd = 1'b0;
  logic [DW-1:0] prev_val = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vram_arbiter3 #(.ADDR_W(AW), .DATA_W(DW)) i_vram_arbiter3 (.*);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) ram[i] <= DW'(i * 16'h1111) ^ 16'h5a5a;
      mem_rdata <= '0;
    end else if (!mem_ce_n) begin
      if (!mem_we_n) ram[mem_addr[3:0]] <= mem_wdata;
      else           mem_rdata <= ram[mem_addr[3:0]];
    end
  end

  function automatic int exp_grant(logic c, logic e, logic r, int ef);
    if (!c) return G_CPU;
    if (!e && !r) return ef ? G_ENG : G_RFR;
    if (!e) return G_ENG;
    if (!r) return G_RFR;
    return G_NONE;
  endfunction

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic c, logic cw, logic e, logic ew, logic r,
                       logic [3:0] ca, logic [3:0] ea, logic [3:0] ra,
                       logic [DW-1:0] cd, logic [DW-1:0] ed);
    cpu_ce_n = c; cpu_we_n = cw; cpu_addr = AW'(ca); cpu_wdata = cd;
    eng_ce_n = e; eng_we_n = ew; eng_addr = AW'(ea); eng_wdata = ed;
    rfr_ce_n = r; rfr_addr = AW'(ra);
  endtask

  // Drive at negedge, check 1 ns later, model state advances for the next edge.
  task automatic step(logic c, logic cw, logic e, logic ew, logic r,
                      logic [3:0] ca, logic [3:0] ea, logic [3:0] ra,
                      logic [DW-1:0] cd, logic [DW-1:0] ed);
    int g;
    logic [3:0] ea_x;
    logic [DW-1:0] wd_x;
    logic we_x;
    @(negedge clk);
    drive(c, cw, e, ew, r, ca, ea, ra, cd, ed);
    #1;
    // R7 / R8: previous-cycle owner receives the word, others zero
    if (prev_g == G_CPU && prev_rd) check("R8", cpu_rdata == prev_val, 32'(cpu_rdata), 32'(prev_val));
    else if (prev_g != G_CPU)       check("R7", cpu_rdata == '0, 32'(cpu_rdata), 0);
    if (prev_g == G_ENG && prev_rd) check("R7", eng_rdata == prev_val, 32'(eng_rdata), 32'(prev_val));
    else if (prev_g != G_ENG)       check("R7", eng_rdata == '0, 32'(eng_rdata), 0);
    if (prev_g == G_RFR)            check("R7", rfr_rdata == prev_val, 32'(rfr_rdata), 32'(prev_val));
    else                            check("R7", rfr_rdata == '0, 32'(rfr_rdata), 0);
    g = exp_grant(c, e, r, eng_first);
    check(g == G_CPU ? "R1" : (g == G_NONE ? "R6" : "R3"),
          {eng_ack_nxt, rfr_ack_nxt, mem_ce_n} == {g == G_ENG, g == G_RFR, g == G_NONE},
          {29'd0, eng_ack_nxt, rfr_ack_nxt, mem_ce_n},
          {29'd0, g == G_ENG, g == G_RFR, g == G_NONE});
    if (g != G_NONE) begin
      ea_x = (g == G_CPU) ? ca : (g == G_ENG ? ea : ra);
      we_x = (g == G_CPU) ? cw : (g == G_ENG ? ew : 1'b1);
      wd_x = (g == G_CPU) ? cd : (g == G_ENG ? ed : '0);
      check(g == G_RFR ? "R5" : "R2",
            mem_addr == AW'(ea_x) && mem_we_n == we_x && (we_x || mem_wdata == wd_x) &&
            (g != G_RFR || mem_wdata == '0),
            {mem_addr[3:0], mem_we_n, mem_wdata}, {ea_x, we_x, wd_x});
      prev_rd  = we_x;
      prev_val = ram[ea_x];
    end else begin
      check("R6", mem_we_n == 1'b1, 32'(mem_we_n), 1);
      prev_rd = 1'b0;
    end
    if (g == G_ENG) eng_first = 0;
    if (g == G_RFR) eng_first = 1;
    prev_g = g;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0;
    drive(1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", mem_ce_n && !eng_ack_nxt && !rfr_ack_nxt, {29'd0, mem_ce_n, eng_ack_nxt, rfr_ack_nxt}, 32'h4);
    check("R9", cpu_rdata == 0 && eng_rdata == 0 && rfr_rdata == 0, 32'(cpu_rdata | eng_rdata | rfr_rdata), 0);
    rst_n = 1'b1;
    // R6: idle
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    // R3: contention after reset, engine first, then alternate
    step(1, 1, 0, 1, 0, 0, 4'd2, 4'd3, 0, 0);
    step(1, 1, 0, 1, 0, 0, 4'd5, 4'd6, 0, 0);
    step(1, 1, 0, 1, 0, 0, 4'd7, 4'd8, 0, 0);
    // R4: processor blocks both for several cycles; pointer held
    step(0, 1, 0, 1, 0, 4'd1, 4'd9, 4'd10, 0, 0);
    step(0, 0, 0, 1, 0, 4'd1, 4'd9, 4'd10, 16'hbeef, 0);
    step(0, 1, 0, 1, 0, 4'd1, 4'd9, 4'd10, 0, 0);
    step(1, 1, 0, 1, 0, 0, 4'd9, 4'd10, 0, 0);
    // R2: single requester each
    step(1, 1, 1, 1, 0, 0, 0, 4'd11, 0, 0);
    step(1, 1, 0, 0, 1, 0, 4'd12, 0, 0, 16'hcafe);
    step(1, 1, 0, 1, 1, 0, 4'd12, 0, 0, 0);
    // R8: back-to-back processor reads
    step(0, 1, 1, 1, 1, 4'd1, 0, 0, 0, 0);
    step(0, 1, 1, 1, 1, 4'd12, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 10) >= 3, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
           4'($urandom), 4'($urandom), 4'($urandom), 16'($urandom), 16'($urandom));
    end
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule